// File: doc/BRIEF.md
# DMA Request Multiplexer Output Channel

This block is one output lane of a DMA request multiplexer. A configuration write picks one of several incoming request lines, which can come from peripherals or from request generators, and the chosen line is passed to a single DMA channel. The block counts every transfer that the DMA acknowledges. When a programmed number of transfers has been served it raises a one-cycle event pulse, which other logic can use to chain a further transfer or to drop a wake-up request. A programmed limit of N gives one event every N+1 transfers, so a limit of zero gives an event after each transfer.

An optional synchronization gate can hold the request back. With the gate enabled, nothing is forwarded until a rising edge arrives on a selected sync line. The block then forwards one batch of N+1 transfers and closes the gate again until the next edge. A one-cycle gap follows every accepted acknowledge, so a peripheral that is slow to drop its request is not counted twice.

The control is a four-state machine. FORWARD (ST_FWD) passes the selected request through. GAP (ST_GAP) holds the output low for the cycle after an accepted acknowledge. ARM (ST_ARM) is a one-cycle settling state after a write that enables sync. WAIT (ST_WAIT) holds the request until a sync edge. The transitions are:

- FORWARD to GAP on an accepted acknowledge.
- FORWARD to WAIT on the batch-closing acknowledge when sync is on.
- GAP to FORWARD always.
- ARM to WAIT always.
- WAIT to FORWARD on a sync rising edge.
- Any state to ARM or to FORWARD on a configuration write, depending on the sync-enable bit being written.

Top module: `reqmux_channel`

## Requirements
- R1: After reset the configuration is all zero: line 0 is selected, sync is off, events are off and the count is 0. `dma_req` follows `req_in[0]` alone and `evt_out` is low.
- R2: With sync off, `dma_req` equals `req_in[cfg_req_id]`. No other request line has any effect on it.
- R3: A `cfg_req_id` value of NUM_REQ or above selects no line, and `dma_req` stays low.
- R4: An acknowledge is accepted when `dma_ack` and `dma_req` are both high in the same cycle. In the cycle after an accepted acknowledge, `dma_req` is low even if the selected line is still high. It follows the line again one cycle later.
- R5: A `dma_ack` that arrives while `dma_req` is low is ignored and is not counted.
- R6: With events enabled and limit N in `cfg_nbreq`, `evt_out` is high for exactly one cycle, the cycle after every (N+1)-th accepted acknowledge. The count then restarts from zero. With N = 0, every acknowledge gives an event.
- R7: With `cfg_evt_en` low, `evt_out` never rises.
- R8: A write with `cfg_sync_en` high closes the gate. `dma_req` stays low until a rising edge on `sync_in[cfg_sync_id]`, where a rising edge is high in one cycle after low in the cycle before. Forwarding starts in the cycle after the edge cycle. A line that is already high when the write happens does not count as an edge.
- R9: With sync on, after N+1 accepted acknowledges the gate closes again, and `dma_req` stays low until the next rising edge.
- R10: In a cycle with `cfg_wr` high, `dma_req` is low and acknowledges are ignored. The write sets the transfer count back to zero.
- R11: Sync lines other than `sync_in[cfg_sync_id]` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_req_id | input | $clog2(NUM_REQ) | Request line to forward |
| cfg_sync_en | input | 1 | Enable the sync gate |
| cfg_evt_en | input | 1 | Enable event pulses |
| cfg_nbreq | input | CNT_W | Transfers per event minus one |
| cfg_sync_id | input | $clog2(NUM_SYNC) | Sync line selector |
| req_in | input | NUM_REQ | Incoming request lines |
| sync_in | input | NUM_SYNC | Sync event lines |
| dma_ack | input | 1 | DMA completion of the forwarded request |
| dma_req | output | 1 | Request toward the DMA channel |
| evt_out | output | 1 | One-cycle event pulse |

## Verification
Request patterns set only the selected line and then every line except it, which tells a correct line decode apart from a wrong index or an OR of the lines. Acknowledge trains are applied with limits of 0, 1 and 2. Some of these include acknowledges while the request is low, or a reprogramming write between transfers, so that counting unaccepted acknowledges, missing the count reset and shifting the event by one cycle each move the pulse to a different cycle. The sync sequences present a level that is already high at the write, edges on lines that are not selected, and then a real edge. This separates true edge detection from level sensing and from the wrong line, and a second batch shows whether the gate closes again.

// File: rtl/reqmux_pkg.sv
package reqmux_pkg;

    // Control states of one multiplexer output lane
    typedef enum logic [1:0] {
        ST_FWD  = 2'd0,  // forward the selected request
        ST_GAP  = 2'd1,  // one idle cycle after an accepted acknowledge
        ST_ARM  = 2'd2,  // settle the edge detector after a sync-enabling write
        ST_WAIT = 2'd3   // hold the request until a sync rising edge
    } lane_state_e;

endpackage

// File: rtl/reqmux_sel.sv
module reqmux_sel #(
    parameter int N     = 12,
    parameter int SEL_W = 4
) (
    input  logic [N-1:0]     lines,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [N-1:0] match;

    // One comparator per line; an index outside 0..N-1 matches nothing
    for (genvar i = 0; i < N; i++) begin : g_line
        assign match[i] = lines[i] && (sel == SEL_W'(i));
    end

    assign hit = |match;
endmodule

// File: rtl/reqmux_cfg.sv
module reqmux_cfg #(
    parameter int REQ_W  = 4,
    parameter int SYNC_W = 2,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REQ_W-1:0]  wr_req_id,
    input  logic              wr_sync_en,
    input  logic              wr_evt_en,
    input  logic [CNT_W-1:0]  wr_nbreq,
    input  logic [SYNC_W-1:0] wr_sync_id,
    output logic [REQ_W-1:0]  req_id,
    output logic              sync_en,
    output logic              evt_en,
    output logic [CNT_W-1:0]  nbreq,
    output logic [SYNC_W-1:0] sync_id
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_id  <= '0;
            sync_en <= 1'b0;
            evt_en  <= 1'b0;
            nbreq   <= '0;
            sync_id <= '0;
        end else if (wr) begin
            req_id  <= wr_req_id;
            sync_en <= wr_sync_en;
            evt_en  <= wr_evt_en;
            nbreq   <= wr_nbreq;
            sync_id <= wr_sync_id;
        end
    end
endmodule

// File: rtl/reqmux_ctrl.sv
module reqmux_ctrl
    import reqmux_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             wr_sync_en,
    input  logic             sync_en,
    input  logic             evt_en,
    input  logic [CNT_W-1:0] nbreq,
    input  logic             req_hit,
    input  logic             sync_hit,
    input  logic             dma_ack,
    output logic             dma_req,
    output logic             evt_out
);
    lane_state_e      state, nxt;
    logic [CNT_W-1:0] served;
    logic             sync_prev;
    logic             sync_rise;
    logic             ack_ok;
    logic             last;
    logic             evt_q;

    assign sync_rise = sync_hit && !sync_prev;
    assign last      = (served == nbreq);
    assign ack_ok    = dma_ack && dma_req;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_FWD:  if (ack_ok) nxt = (sync_en && last) ? ST_WAIT : ST_GAP;
            ST_GAP:  nxt = ST_FWD;
            ST_ARM:  nxt = ST_WAIT;
            ST_WAIT: if (sync_rise) nxt = ST_FWD;
        endcase
        if (cfg_wr) nxt = wr_sync_en ? ST_ARM : ST_FWD;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FWD;
        else        state <= nxt;
    end

    // Outputs
    always_comb begin
        dma_req = 1'b0;
        unique case (state)
            ST_FWD:  dma_req = req_hit && !cfg_wr;
            ST_GAP:  dma_req = 1'b0;
            ST_ARM:  dma_req = 1'b0;
            ST_WAIT: dma_req = 1'b0;
        endcase
        evt_out = evt_q;
    end

    // Served-transfer counter, event register and sync edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            served    <= '0;
            evt_q     <= 1'b0;
            sync_prev <= 1'b0;
        end else begin
            sync_prev <= sync_hit;
            evt_q     <= ack_ok && last && evt_en;
            if (cfg_wr)      served <= '0;
            else if (ack_ok) served <= last ? '0 : served + 1'b1;
        end
    end

    // R4: the cycle after an accepted acknowledge carries no request
    a_r4_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |=> !dma_req);

    // R6: event pulses are one cycle wide
    a_r6_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt_out |=> !evt_out);

    // R6: the count never passes the programmed limit
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        served <= nbreq);

    // R7: no event without an accepted acknowledge while events are enabled
    a_r7_evt_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_ok && evt_en) |=> !evt_out);

    // R9: the batch-closing acknowledge in sync mode closes the gate
    a_r9_gate_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ok && sync_en && last) |=> (state == ST_WAIT));

    // R10: a configuration write clears the count
    a_r10_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (served == '0));
endmodule

// File: rtl/reqmux_channel.sv
module reqmux_channel #(
    parameter int NUM_REQ  = 12,
    parameter int NUM_SYNC = 4,
    parameter int CNT_W    = 4,
    localparam int REQ_W   = (NUM_REQ  > 1) ? $clog2(NUM_REQ)  : 1,
    localparam int SYNC_W  = (NUM_SYNC > 1) ? $clog2(NUM_SYNC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [REQ_W-1:0]    cfg_req_id,
    input  logic                cfg_sync_en,
    input  logic                cfg_evt_en,
    input  logic [CNT_W-1:0]    cfg_nbreq,
    input  logic [SYNC_W-1:0]   cfg_sync_id,
    input  logic [NUM_REQ-1:0]  req_in,
    input  logic [NUM_SYNC-1:0] sync_in,
    input  logic                dma_ack,
    output logic                dma_req,
    output logic                evt_out
);
    logic [REQ_W-1:0]  req_id_q;
    logic              sync_en_q;
    logic              evt_en_q;
    logic [CNT_W-1:0]  nbreq_q;
    logic [SYNC_W-1:0] sync_id_q;
    logic              req_hit;
    logic              sync_hit;

    reqmux_cfg #(.REQ_W(REQ_W), .SYNC_W(SYNC_W), .CNT_W(CNT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (cfg_wr),
        .wr_req_id  (cfg_req_id),
        .wr_sync_en (cfg_sync_en),
        .wr_evt_en  (cfg_evt_en),
        .wr_nbreq   (cfg_nbreq),
        .wr_sync_id (cfg_sync_id),
        .req_id     (req_id_q),
        .sync_en    (sync_en_q),
        .evt_en     (evt_en_q),
        .nbreq      (nbreq_q),
        .sync_id    (sync_id_q)
    );

    reqmux_sel #(.N(NUM_REQ), .SEL_W(REQ_W)) u_req_sel (
        .lines (req_in),
        .sel   (req_id_q),
        .hit   (req_hit)
    );

    reqmux_sel #(.N(NUM_SYNC), .SEL_W(SYNC_W)) u_sync_sel (
        .lines (sync_in),
        .sel   (sync_id_q),
        .hit   (sync_hit)
    );

    reqmux_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .wr_sync_en (cfg_sync_en),
        .sync_en    (sync_en_q),
        .evt_en     (evt_en_q),
        .nbreq      (nbreq_q),
        .req_hit    (req_hit),
        .sync_hit   (sync_hit),
        .dma_ack    (dma_ack),
        .dma_req    (dma_req),
        .evt_out    (evt_out)
    );

    // R3: an index past the last line never produces a request
    a_r3_oob_id: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, req_id_q} >= (REQ_W+1)'(NUM_REQ)) |-> !dma_req);

    // R2: with the gate open, a request needs the selected line to be high
    a_r2_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> req_in[req_id_q]);
endmodule

// File: tb/reqmux_channel_test.sv
module reqmux_channel_test;
    localparam int NUM_REQ  = 12;
    localparam int NUM_SYNC = 4;
    localparam int CNT_W    = 4;

    typedef struct {
        logic  r;
        logic  e;
        string tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_wr = 1'b0;
    logic [3:0]          cfg_req_id = '0;
    logic                cfg_sync_en = 1'b0;
    logic                cfg_evt_en = 1'b0;
    logic [CNT_W-1:0]    cfg_nbreq = '0;
    logic [1:0]          cfg_sync_id = '0;
    logic [NUM_REQ-1:0]  req_in = '0;
    logic [NUM_SYNC-1:0] sync_in = '0;
    logic                dma_ack = 1'b0;
    logic                dma_req;
    logic                evt_out;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    reqmux_channel #(.NUM_REQ(NUM_REQ), .NUM_SYNC(NUM_SYNC), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_req_id(cfg_req_id),
        .cfg_sync_en(cfg_sync_en), .cfg_evt_en(cfg_evt_en), .cfg_nbreq(cfg_nbreq),
        .cfg_sync_id(cfg_sync_id), .req_in(req_in), .sync_in(sync_in),
        .dma_ack(dma_ack), .dma_req(dma_req), .evt_out(evt_out)
    );

    // Monitor: compare each cycle's outputs with the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                n_chk++;
                if (dma_req !== x.r) begin
                    n_bad++;
                    $display("FAIL %s dma_req actual=%b expected=%b", x.tag, dma_req, x.r);
                end
                n_chk++;
                if (evt_out !== x.e) begin
                    n_bad++;
                    $display("FAIL %s evt_out actual=%b expected=%b", x.tag, evt_out, x.e);
                end
            end
        end
    end

    // Driver: apply one cycle of stimulus and queue its expected outputs
    task automatic cyc(input logic [NUM_REQ-1:0] r, input logic [NUM_SYNC-1:0] s,
                       input logic a, input logic er, input logic ee, input string tag);
        req_in  = r;
        sync_in = s;
        dma_ack = a;
        q.push_back('{er, ee, tag});
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] id, input logic sen, input logic een,
                      input logic [CNT_W-1:0] nb, input logic [1:0] sid,
                      input logic [NUM_REQ-1:0] r, input logic [NUM_SYNC-1:0] s,
                      input logic ee, input string tag);
        cfg_wr      = 1'b1;
        cfg_req_id  = id;
        cfg_sync_en = sen;
        cfg_evt_en  = een;
        cfg_nbreq   = nb;
        cfg_sync_id = sid;
        req_in      = r;
        sync_in     = s;
        dma_ack     = 1'b1;
        q.push_back('{1'b0, ee, tag});
        @(negedge clk);
        cfg_wr  = 1'b0;
        dma_ack = 1'b0;
    endtask

    localparam logic [NUM_REQ-1:0] L5 = 12'h020;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, line 0 passes through alone
        cyc(12'h001, 4'h0, 1'b0, 1'b1, 1'b0, "R1 line0 high");
        cyc(12'hFFE, 4'h0, 1'b0, 1'b0, 1'b0, "R1 others high");

        // R10/R2/R6/R4: select line 5, events every transfer
        wr(4'd5, 1'b0, 1'b1, 4'd0, 2'd0, 12'hFFF, 4'h0, 1'b0, "R10 low during write");
        cyc(L5,      4'h0, 1'b0, 1'b1, 1'b0, "R2 selected line");
        cyc(12'hFDF, 4'h0, 1'b0, 1'b0, 1'b0, "R2 other lines");
        cyc(L5,      4'h0, 1'b1, 1'b1, 1'b0, "R6 ack n0");
        cyc(L5,      4'h0, 1'b0, 1'b0, 1'b1, "R4 gap / R6 event");
        cyc(L5,      4'h0, 1'b0, 1'b1, 1'b0, "R4 resume");
        cyc(L5,      4'h0, 1'b1, 1'b1, 1'b0, "R6 second ack");
        cyc(L5,      4'h0, 1'b0, 1'b0, 1'b1, "R6 second event");

        // R5/R6: limit 2, stray acks while low are not counted
        wr(4'd5, 1'b0, 1'b1, 4'd2, 2'd0, L5, 4'h0, 1'b0, "R10 write n2");
        cyc(12'h000, 4'h0, 1'b1, 1'b0, 1'b0, "R5 stray ack 1");
        cyc(12'h000, 4'h0, 1'b1, 1'b0, 1'b0, "R5 stray ack 2");
        cyc(L5,      4'h0, 1'b1, 1'b1, 1'b0, "R6 ack 1 of 3");
        cyc(L5,      4'h0, 1'b0, 1'b0, 1'b0, "R5 no early event");
        cyc(L5,      4'h0, 1'b1, 1'b1, 1'b0, "R6 ack 2 of 3");
        cyc(L5,      4'h0, 1'b0, 1'b0, 1'b0, "R5 no early event 2");
        cyc(L5,      4'h0, 1'b1, 1'b1, 1'b0, "R6 ack 3 of 3");
        cyc(L5,      4'h0, 1'b0, 1'b0, 1'b1, "R6 event after 3");

        // R7: events disabled
        wr(4'd5, 1'b0, 1'b0, 4'd0, 2'd0, L5, 4'h0, 1'b0, "R7 write");
        cyc(L5,      4'h0, 1'b1, 1'b1, 1'b0, "R7 ack");
        cyc(L5,      4'h0, 1'b0, 1'b0, 1'b0, "R7 no event");

        // R10: a write restarts the count
        wr(4'd5, 1'b0, 1'b1, 4'd1, 2'd0, L5, 4'h0, 1'b0, "R10 write n1");
        cyc(L5,      4'h0, 1'b1, 1'b1, 1'b0, "R10 ack before rewrite");
        cyc(L5,      4'h0, 1'b0, 1'b0, 1'b0, "R10 gap");
        wr(4'd5, 1'b0, 1'b1, 4'd1, 2'd0, L5, 4'h0, 1'b0, "R10 rewrite");
        cyc(L5,      4'h0, 1'b1, 1'b1, 1'b0, "R10 ack 1 after rewrite");
        cyc(L5,      4'h0, 1'b0, 1'b0, 1'b0, "R10 count was cleared");
        cyc(L5,      4'h0, 1'b1, 1'b1, 1'b0, "R10 ack 2 after rewrite");
        cyc(L5,      4'h0, 1'b0, 1'b0, 1'b1, "R10 event after 2");

        // R3: out-of-range index
        wr(4'd13, 1'b0, 1'b1, 4'd0, 2'd0, 12'hFFF, 4'h0, 1'b0, "R3 write");
        cyc(12'hFFF, 4'h0, 1'b0, 1'b0, 1'b0, "R3 all high");
        cyc(12'hFFF, 4'h0, 1'b1, 1'b0, 1'b0, "R3 ack");
        cyc(12'hFFF, 4'h0, 1'b0, 1'b0, 1'b0, "R3 no event");

        // R8/R9/R11: sync gate on line 2, limit 1, line already high at write
        wr(4'd5, 1'b1, 1'b1, 4'd1, 2'd2, L5, 4'h4, 1'b0, "R8 write");
        cyc(L5, 4'h4, 1'b0, 1'b0, 1'b0, "R8 arm");
        cyc(L5, 4'h4, 1'b0, 1'b0, 1'b0, "R8 level is not edge");
        cyc(L5, 4'h0, 1'b0, 1'b0, 1'b0, "R8 line low");
        cyc(L5, 4'hB, 1'b0, 1'b0, 1'b0, "R11 other sync lines");
        cyc(L5, 4'h4, 1'b0, 1'b0, 1'b0, "R8 edge cycle");
        cyc(L5, 4'h4, 1'b1, 1'b1, 1'b0, "R8 forwarding");
        cyc(L5, 4'h4, 1'b0, 1'b0, 1'b0, "R4 gap in sync");
        cyc(L5, 4'h4, 1'b1, 1'b1, 1'b0, "R9 last of batch");
        cyc(L5, 4'h4, 1'b0, 1'b0, 1'b1, "R9 closed / R6 event");
        cyc(L5, 4'h0, 1'b0, 1'b0, 1'b0, "R9 still closed");
        cyc(L5, 4'h4, 1'b0, 1'b0, 1'b0, "R9 new edge");
        cyc(L5, 4'h4, 1'b0, 1'b1, 1'b0, "R8 reopened");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule